// File: doc/BRIEF.md
# Two-Pulse Clutter Canceller

This block removes stationary returns from a pulse-Doppler frame before the Doppler transform. Range-bin samples arrive as signed I/Q pairs, one chirp after another. For every sample the block subtracts the sample taken at the same range bin on the previous chirp, and it does this separately for I and for Q. A return that does not change from chirp to chirp therefore cancels to zero, while a moving target leaves a residue.

One chirp of history is held inside the block. The first chirp of each frame has no earlier chirp to subtract, so every sample of that chirp comes out as zero. A frame is a fixed number of chirps, each with a fixed number of bins, sent in chirp-major order. The position counters wrap on their own at the frame boundary. A `frame_start` pulse can also force a restart at any time. When the `enable` input is low, the block passes each input through unchanged, sign-extended to the output width. The history is still updated in that case, so the block can be switched back on in the middle of a frame.

Each result appears on the cycle after its input. The block has no handshake and never stalls.

Top module: `mti_canceller`

## Requirements
- R1: With `enable` high, for every chirp except the first chirp of a frame, `out_i` = `in_i` minus the I sample at the same bin index on the previous chirp. `out_q` is formed the same way from Q. Both are exact integer differences.
- R2: With `enable` high, every output sample of the first chirp of a frame is zero on both I and Q.
- R3: With `enable` low, `out_i` and `out_q` equal `in_i` and `in_q` exactly, sign-extended by one bit.
- R4: The 17-bit signed outputs never wrap. The extreme differences 32767-(-32768)=65535 and -32768-32767=-65535 come out exactly.
- R5: `out_valid` is `in_valid` delayed by exactly one clock cycle. The result for each sample appears on that same cycle.
- R6: A frame is 32 chirps of 64 bins each. Once 32×64 valid samples have been received, the next chirp is treated as the first chirp of a new frame, even with no `frame_start` pulse.
- R7: A `frame_start` pulse restarts the position count at bin 0 of chirp 0. If `in_valid` is high in the same cycle, that sample is bin 0 of the first chirp.
- R8: The history is updated by every valid sample, including samples taken while `enable` is low. A chirp processed after a bypassed chirp subtracts the bypassed chirp's samples.
- R9: While `in_valid` is low, `out_i` and `out_q` keep their last values.
- R10: After reset, `out_valid`, `out_i` and `out_q` are zero, and the next chirp is treated as a first chirp.
- R11: Cycles with `in_valid` low do not advance the bin or chirp position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Single-cycle restart of the frame position |
| enable | input | 1 | 1 = cancel, 0 = bit-exact pass-through |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Signed I sample |
| in_q | input | 16 | Signed Q sample |
| out_valid | output | 1 | Output sample strobe, one cycle after `in_valid` |
| out_i | output | 17 | Signed I difference or bypassed sample |
| out_q | output | 17 | Signed Q difference or bypassed sample |

## Verification
Two functions can land in the same cycle: the frame restart and the processing of a sample. The bench raises `frame_start` together with a valid sample in the middle of a chirp. It expects a zero output for that sample and for the rest of the new first chirp, followed by ordinary differences against the restarted history. It also raises `frame_start` together with a bypassed sample, where the pass-through value must win. A further case combines the automatic frame wrap with a bypass-then-enable transition. All expected values come from a bench model that tracks bin, chirp and history independently of the RTL.

// File: rtl/mti_canceller.sv
module mti_canceller #(
  parameter int DATA_W = 16,
  parameter int BINS   = 64,
  parameter int CHIRPS = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_start,
  input  logic                     enable,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  output logic                     out_valid,
  output logic signed [DATA_W:0]   out_i,
  output logic signed [DATA_W:0]   out_q
);
  localparam int OUT_W   = DATA_W + 1;
  localparam int BIN_W   = $clog2(BINS);
  localparam int CHIRP_W = $clog2(CHIRPS);

  logic [BIN_W-1:0]         bin_q;
  logic [CHIRP_W-1:0]       chirp_q;
  logic signed [DATA_W-1:0] hist_i [BINS];
  logic signed [DATA_W-1:0] hist_q [BINS];

  wire [BIN_W-1:0]   bin_a   = frame_start ? '0 : bin_q;
  wire [CHIRP_W-1:0] chirp_a = frame_start ? '0 : chirp_q;
  wire first      = (chirp_a == '0);
  wire bin_last   = (bin_a == BIN_W'(BINS - 1));
  wire chirp_last = (chirp_a == CHIRP_W'(CHIRPS - 1));

  wire signed [OUT_W-1:0] cur_i  = {in_i[DATA_W-1], in_i};
  wire signed [OUT_W-1:0] cur_q  = {in_q[DATA_W-1], in_q};
  wire signed [OUT_W-1:0] prev_i = {hist_i[bin_a][DATA_W-1], hist_i[bin_a]};
  wire signed [OUT_W-1:0] prev_q = {hist_q[bin_a][DATA_W-1], hist_q[bin_a]};

  wire signed [OUT_W-1:0] res_i = !enable ? cur_i : first ? '0 : cur_i - prev_i;
  wire signed [OUT_W-1:0] res_q = !enable ? cur_q : first ? '0 : cur_q - prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bin_q   <= '0;
      chirp_q <= '0;
    end else if (in_valid) begin
      bin_q <= bin_last ? '0 : bin_a + BIN_W'(1);
      if (bin_last) chirp_q <= chirp_last ? '0 : chirp_a + CHIRP_W'(1);
      else          chirp_q <= chirp_a;
    end else if (frame_start) begin
      bin_q   <= '0;
      chirp_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      hist_i[bin_a] <= in_i;
      hist_q[bin_a] <= in_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= res_i;
        out_q <= res_q;
      end
    end
  end
endmodule

// File: rtl/mti_canceller_chk.sv
module mti_canceller_chk #(
  parameter int DATA_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     frame_start,
  input logic                     enable,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] in_i,
  input logic signed [DATA_W-1:0] in_q,
  input logic                     out_valid,
  input logic signed [DATA_W:0]   out_i,
  input logic signed [DATA_W:0]   out_q
);
  p_valid_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_novalid_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_bypass_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !enable) |=> (out_i == $past(in_i)) && (out_q == $past(in_q)));
  p_restart_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enable && frame_start) |=> (out_i == '0) && (out_q == '0));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_i) && $stable(out_q));
endmodule

bind mti_canceller mti_canceller_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .enable(enable),
  .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
  .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
);

// File: tb/mti_canceller_tb_top.sv
`timescale 1ns/1ps
module mti_canceller_tb_top;
  localparam int BINS = 64, CHIRPS = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 1'b0, enable = 1'b1, in_valid = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic out_valid;
  logic signed [16:0] out_i, out_q;

  always #4 clk = ~clk;

  mti_canceller dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .enable(enable),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int n_chk = 0, n_pass = 0;
  int mh_i [BINS];
  int mh_q [BINS];
  int mbin = 0, mchirp = 0;
  int last_i = 0, last_q = 0;
  bit done = 0;

  function automatic int expect_val(bit en, bit first, int cur, int prev);
    if (!en) return cur;
    if (first) return 0;
    return cur - prev;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act == exp) n_pass++;
    else $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
  endtask

  task automatic step(bit v, bit fs, bit en, int di, int dq, string tag);
    int b, c, ei, eq;
    string t;
    @(negedge clk);
    in_valid = v; frame_start = fs; enable = en;
    in_i = 16'(di); in_q = 16'(dq);
    if (v) begin
      b = fs ? 0 : mbin;
      c = fs ? 0 : mchirp;
      ei = expect_val(en, c == 0, di, mh_i[b]);
      eq = expect_val(en, c == 0, dq, mh_q[b]);
      mh_i[b] = di; mh_q[b] = dq;
      mbin = (b == BINS-1) ? 0 : b + 1;
      mchirp = (b == BINS-1) ? ((c == CHIRPS-1) ? 0 : c + 1) : c;
      last_i = ei; last_q = eq;
      t = (tag != "") ? tag : (!en ? "R3" : (c == 0 ? "R2" : "R1"));
    end else begin
      if (fs) begin mbin = 0; mchirp = 0; end
      t = (tag != "") ? tag : "R9 R11";
    end
    @(negedge clk);
    in_valid = 0; frame_start = 0;
    check({t, " R5 out_valid"}, int'(out_valid), int'(v));
    check({t, " out_i"}, int'(out_i), last_i);
    check({t, " out_q"}, int'(out_q), last_q);
  endtask

  task automatic rnd_chirp(bit en, string tag, bit gaps);
    for (int k = 0; k < BINS; k++) begin
      if (gaps && ($urandom % 4 == 0)) step(0, 0, en, 0, 0, "R9 R11");
      step(1, 0, en, int'($signed(16'($urandom))), int'($signed(16'($urandom))), tag);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_pass, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R10 out_valid", int'(out_valid), 0);
    check("R10 out_i", int'(out_i), 0);
    check("R10 out_q", int'(out_q), 0);
    rst_n = 1;

    rnd_chirp(1, "R10", 0);
    for (int c = 1; c < 4; c++) rnd_chirp(1, "", 1);

    step(1, 1, 1, 1234, -999, "R7");
    for (int k = 1; k < BINS; k++)
      step(1, 0, 1, int'($signed(16'($urandom))), int'($signed(16'($urandom))), "R2");
    for (int c = 1; c < CHIRPS; c++) rnd_chirp(1, "", c < 4);
    rnd_chirp(1, "R6", 0);

    rnd_chirp(0, "R3", 1);
    rnd_chirp(1, "R8", 0);

    step(1, 1, 1, -32768, 32767, "R2");
    for (int k = 1; k < BINS; k++) step(1, 0, 1, -32768, 32767, "R2");
    for (int k = 0; k < BINS; k++) step(1, 0, 1, 32767, -32768, "R4");
    for (int k = 0; k < BINS; k++) step(1, 0, 1, -32768, 32767, "R4");

    for (int k = 0; k < 20; k++)
      step(1, 0, 1, int'($signed(16'($urandom))), int'($signed(16'($urandom))), "");
    step(1, 1, 1, 500, 600, "R7");
    for (int k = 1; k < BINS; k++)
      step(1, 0, 1, int'($signed(16'($urandom))), int'($signed(16'($urandom))), "R7");
    rnd_chirp(1, "R7", 1);
    step(1, 1, 0, -7, 9, "R3");
    for (int k = 1; k < BINS; k++)
      step(1, 0, 0, int'($signed(16'($urandom))), int'($signed(16'($urandom))), "R3");
    rnd_chirp(1, "R8", 1);
    step(0, 1, 1, 0, 0, "R9");
    rnd_chirp(1, "R2", 0);
    rnd_chirp(1, "R1", 1);

    done = 1;
    $display("%0d/%0d checks passed", n_pass, n_chk);
    $finish;
  end
endmodule